// File: doc/BRIEF.md
# Bus Master Read/Write Sequencer

This block sits between a simple request port on the processor side and an external byte-wide memory bus. It accepts one transfer at a time. Each transfer carries a 16-bit address, a direction flag and, for writes, one data byte. The block then steps the device control lines through a fixed four-cycle pattern. The address goes out first. The read or write strobe follows, and then the decoded chip select. When the transfer ends, every line returns to its inactive level.

The top address bit is never sent to the devices. It only picks one of two 32K regions, and each region has its own active-low chip select. The low fifteen bits go to the devices directly. Read data is captured from the bus input while the strobe and select are both active, and it stays on the result port until the next read. A one-cycle completion pulse marks the last cycle of every transfer. A busy flag tells the requester when a new transfer may start.

The data bus is modelled as separate in and out vectors plus an output enable. The enable is raised only while a write strobe is active, so the board can build the tri-state driver from it.

Top module: `membus_master`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, the outputs sit at their idle levels: `mem_cs_n` = 2'b11, `mem_rd_n` = 1, `mem_wr_n` = 1, `mem_doe` = 0, `busy` = 0, `done` = 0, `rd_data` = 0.
- R2: A request (`req_valid` high) is taken at a rising edge only when `busy` is low. Address, direction and write data are sampled at that edge. Request inputs seen while `busy` is high, and later changes to them, have no effect on the transfer in progress.
- R3: Bit 15 of the address selects the region. Addresses 0x0000..0x7FFF drive `mem_cs_n[0]` low and 0x8000..0xFFFF drive `mem_cs_n[1]` low. At most one chip select is ever low.
- R4: From the first cycle after acceptance through the fourth, `mem_addr` equals bits 14..0 of the sampled address and does not change.
- R5: Count the cycles after the accepting edge. In cycle 1 no strobe and no select is active. In cycle 2 the strobe is low and the selects are high. In cycle 3 the strobe and the decoded select are both low. In cycle 4 all control lines are high again.
- R6: A read (`req_write` = 0) uses `mem_rd_n` as its strobe. `mem_wr_n` stays high and `mem_doe` stays low for the whole transfer.
- R7: A write (`req_write` = 1) uses `mem_wr_n` as its strobe and leaves `mem_rd_n` high. `mem_doe` is high exactly in cycles 2 and 3, with `mem_dout` equal to the sampled write byte.
- R8: The value on `mem_din` at the end of cycle 3 of a read appears on `rd_data` from cycle 4 on. It is held until the next read reaches cycle 4, and writes leave it unchanged.
- R9: `done` is high only in cycle 4 and only for that one cycle. `busy` is high in cycles 1 to 4 and low otherwise, so back-to-back requests start one cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress; requests ignored |
| done | output | 1 | One-cycle pulse in the last cycle of a transfer |
| rd_data | output | 8 | Last byte read |
| mem_addr | output | 15 | Address lines to the devices |
| mem_dout | output | 8 | Data driven toward the devices |
| mem_din | input | 8 | Data returned by the selected device |
| mem_doe | output | 1 | Enable for the data output driver |
| mem_cs_n | output | 2 | Active-low chip selects, one per 32K region |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |

## Verification
The embedded properties assume that `rst` is held for at least one clock before any request. They also assume that `mem_din` needs no particular value except in cycle 3 of a read. The bench honours both assumptions. Its device model returns a fixed filler byte whenever no select and read strobe are active together, and stored bytes only when exactly one is. The stimulus keeps `req_valid` asserted with changing address and data through some busy windows. This tests that held or altered requests are neither double-accepted nor allowed to change the transfer in progress. The stimulus also covers the region edges 0x7FFF/0x8000 and 0x0000/0xFFFF.

// File: rtl/membus_pkg.sv
package membus_pkg;

    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned REGION_CNT = 2;
    localparam int unsigned SEL_W      = $clog2(REGION_CNT);
    localparam int unsigned DEV_W      = ADDR_W - SEL_W;

    // One state per bus phase; a transfer walks ADDR..RELEASE in order.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ADDR    = 3'd1,
        PH_STROBE  = 3'd2,
        PH_SELECT  = 3'd3,
        PH_RELEASE = 3'd4
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    typedef struct packed {
        logic rd_n;
        logic wr_n;
        logic doe;
        logic sel_en;
    } ctl_t;

    function automatic logic [SEL_W-1:0] region_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: SEL_W];
    endfunction

    function automatic logic [DEV_W-1:0] dev_addr_of(input logic [ADDR_W-1:0] a);
        return a[DEV_W-1:0];
    endfunction

endpackage

// File: rtl/membus_phase.sv
module membus_phase
    import membus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   busy,
    output logic   last
);

    phase_e phase_nx;

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:    if (start) phase_nx = PH_ADDR;
            PH_ADDR:    phase_nx = PH_STROBE;
            PH_STROBE:  phase_nx = PH_SELECT;
            PH_SELECT:  phase_nx = PH_RELEASE;
            PH_RELEASE: phase_nx = PH_IDLE;
            default:    phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nx;
    end

    assign busy = (phase != PH_IDLE);
    assign last = (phase == PH_RELEASE);

    // R5: phases follow the fixed order one cycle each
    a_r5_addr_to_strobe: assert property (@(posedge clk) disable iff (rst)
        phase == PH_ADDR |=> phase == PH_STROBE);
    a_r5_strobe_to_select: assert property (@(posedge clk) disable iff (rst)
        phase == PH_STROBE |=> phase == PH_SELECT);
    a_r5_select_to_release: assert property (@(posedge clk) disable iff (rst)
        phase == PH_SELECT |=> phase == PH_RELEASE);
    // R9: after the last phase the sequencer is idle again
    a_r9_release_to_idle: assert property (@(posedge clk) disable iff (rst)
        phase == PH_RELEASE |=> phase == PH_IDLE);

endmodule

// File: rtl/membus_latch.sv
module membus_latch
    import membus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_t             req,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] mem_din,
    output xfer_t             cur,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (start) begin
            cur <= req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (phase == PH_SELECT && !cur.wr) begin
            rd_data <= mem_din;
        end
    end

    // R8: read result only moves at the end of a read's select phase
    a_r8_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !(phase == PH_SELECT && !cur.wr) |=> $stable(rd_data));

endmodule

// File: rtl/membus_drive.sv
module membus_drive
    import membus_pkg::*;
(
    input  phase_e phase,
    input  logic   wr,
    output ctl_t   ctl
);

    logic strobe_on;

    assign strobe_on = (phase == PH_STROBE) || (phase == PH_SELECT);

    always_comb begin
        ctl.rd_n   = !(strobe_on && !wr);
        ctl.wr_n   = !(strobe_on && wr);
        ctl.doe    = strobe_on && wr;
        ctl.sel_en = (phase == PH_SELECT);
    end

endmodule

// File: rtl/membus_select.sv
module membus_select
    import membus_pkg::*;
(
    input  logic [SEL_W-1:0]      region,
    input  logic                  sel_en,
    output logic [REGION_CNT-1:0] cs_n
);

    for (genvar g = 0; g < REGION_CNT; g++) begin : g_cs
        assign cs_n[g] = !(sel_en && (region == SEL_W'(g)));
    end

endmodule

// File: rtl/membus_master.sv
module membus_master
    import membus_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data,
    output logic [DEV_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]     mem_dout,
    input  logic [DATA_W-1:0]     mem_din,
    output logic                  mem_doe,
    output logic [REGION_CNT-1:0] mem_cs_n,
    output logic                  mem_rd_n,
    output logic                  mem_wr_n
);

    phase_e phase;
    xfer_t  req;
    xfer_t  cur;
    ctl_t   ctl;
    logic   start;
    logic   cs_active;
    logic   strobe_active;

    assign start = req_valid && !busy;

    always_comb begin
        req.wr    = req_write;
        req.addr  = req_addr;
        req.wdata = req_wdata;
    end

    membus_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .phase (phase),
        .busy  (busy),
        .last  (done)
    );

    membus_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .req     (req),
        .phase   (phase),
        .mem_din (mem_din),
        .cur     (cur),
        .rd_data (rd_data)
    );

    membus_drive u_drive (
        .phase (phase),
        .wr    (cur.wr),
        .ctl   (ctl)
    );

    membus_select u_select (
        .region (region_of(cur.addr)),
        .sel_en (ctl.sel_en),
        .cs_n   (mem_cs_n)
    );

    assign mem_addr = dev_addr_of(cur.addr);
    assign mem_dout = cur.wdata;
    assign mem_doe  = ctl.doe;
    assign mem_rd_n = ctl.rd_n;
    assign mem_wr_n = ctl.wr_n;

    assign cs_active     = (mem_cs_n != {REGION_CNT{1'b1}});
    assign strobe_active = !mem_rd_n || !mem_wr_n;

    // R3: never two devices selected together
    a_r3_one_select: assert property (@(posedge clk) disable iff (rst)
        $countones(~mem_cs_n) <= 1);
    // R5: a select only falls while a strobe was already active
    a_r5_strobe_before_select: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_active) |-> strobe_active && $past(strobe_active));
    // R6: read and write strobes are exclusive
    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_wr_n));
    // R7: data driver only on with an active write strobe
    a_r7_doe_with_write: assert property (@(posedge clk) disable iff (rst)
        mem_doe |-> !mem_wr_n && mem_rd_n);
    // R4: device address frozen while the transfer runs
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> $stable(mem_addr));
    // R9: done is a single-cycle pulse followed by idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);
    // R2: no acceptance while busy, so busy never restarts mid transfer
    a_r2_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> busy);

endmodule

// File: tb/membus_master_tb.sv
module membus_master_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done;
    logic [7:0]  rd_data;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din;
    logic        mem_doe;
    logic [1:0]  mem_cs_n;
    logic        mem_rd_n, mem_wr_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    membus_master u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_din(mem_din), .mem_doe(mem_doe), .mem_cs_n(mem_cs_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
    );

    // Device model: two 256-byte banks indexed by the low address byte
    logic [7:0] dev  [2][256];
    logic [7:0] gold [2][256];

    initial begin
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 256; i++) begin
                dev[b][i]  = 8'(i * 7 + b * 91);
                gold[b][i] = 8'(i * 7 + b * 91);
            end
    end

    always_comb begin
        if (!mem_rd_n && mem_cs_n == 2'b10)      mem_din = dev[0][mem_addr[7:0]];
        else if (!mem_rd_n && mem_cs_n == 2'b01) mem_din = dev[1][mem_addr[7:0]];
        else                                     mem_din = 8'hEE;
    end

    always @(posedge clk) begin
        if (!mem_wr_n && mem_doe && mem_cs_n == 2'b10) dev[0][mem_addr[7:0]] <= mem_dout;
        if (!mem_wr_n && mem_doe && mem_cs_n == 2'b01) dev[1][mem_addr[7:0]] <= mem_dout;
    end

    // Behavioural reference: cycle count within a transfer plus sampled request
    int         cnt = 0;
    logic       m_wr = 1'b0;
    logic [15:0] m_addr = '0;
    logic [7:0] m_wd = '0;
    logic [7:0] exp_rd = '0;

    always @(posedge clk) begin
        if (rst) begin
            cnt <= 0; m_wr <= 1'b0; m_addr <= '0; m_wd <= '0; exp_rd <= '0;
        end else begin
            case (cnt)
                0: if (req_valid) begin
                       cnt <= 1; m_wr <= req_write; m_addr <= req_addr; m_wd <= req_wdata;
                   end
                3: begin
                       cnt <= 4;
                       if (m_wr) gold[m_addr[15]][m_addr[7:0]] <= m_wd;
                       else      exp_rd <= gold[m_addr[15]][m_addr[7:0]];
                   end
                4: cnt <= 0;
                default: cnt <= cnt + 1;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    logic past_rst = 1'b1;
    always @(posedge clk) past_rst <= rst;

    always @(negedge clk) begin
        logic strobe_on;
        logic [1:0] e_cs;
        strobe_on = (cnt == 2 || cnt == 3);
        e_cs = (cnt == 3) ? (m_addr[15] ? 2'b01 : 2'b10) : 2'b11;
        if (rst || past_rst) begin
            chk("R1 cs_n",  mem_cs_n, 2'b11);
            chk("R1 rd_n",  mem_rd_n, 1'b1);
            chk("R1 wr_n",  mem_wr_n, 1'b1);
            chk("R1 doe",   mem_doe,  1'b0);
            chk("R1 busy",  busy,     1'b0);
            chk("R1 done",  done,     1'b0);
            chk("R1 rd_data", rd_data, 8'h00);
        end else begin
            chk(cnt == 3 ? "R3 cs_n decode" : "R5 cs_n timing", mem_cs_n, e_cs);
            chk("R6 rd_n", mem_rd_n, !(strobe_on && !m_wr));
            chk("R7 wr_n", mem_wr_n, !(strobe_on && m_wr));
            chk("R7 doe",  mem_doe,  strobe_on && m_wr);
            if (strobe_on && m_wr) chk("R7 dout", mem_dout, m_wd);
            if (cnt != 0) chk("R4 mem_addr", mem_addr, m_addr[14:0]);
            chk("R2 busy", busy, cnt != 0);
            chk("R9 done", done, cnt == 4);
            chk("R8 rd_data", rd_data, exp_rd);
        end
    end

    // Issue one transfer; optionally scramble request inputs while busy
    task automatic issue(input logic wr, input logic [15:0] a, input logic [7:0] d, input bit noise);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        do begin @(posedge clk); #1; end while (cnt != 1);
        while (cnt != 4) begin
            if (noise) begin
                req_valid = 1'b1;
                req_write = 1'($urandom);
                req_addr  = 16'($urandom);
                req_wdata = 8'($urandom);
            end else begin
                req_valid = 1'b0;
            end
            @(posedge clk); #1;
        end
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        // R3 R7 R8: same low byte in both regions must stay distinct
        issue(1'b1, 16'h0012, 8'hA5, 1'b0);
        issue(1'b1, 16'h8012, 8'h5A, 1'b1);
        issue(1'b0, 16'h0012, 8'h00, 1'b0);
        issue(1'b0, 16'h8012, 8'h00, 1'b1);
        // R3: region boundaries
        issue(1'b1, 16'h7FFF, 8'h11, 1'b0);
        issue(1'b1, 16'h8000, 8'h22, 1'b0);
        issue(1'b1, 16'h0000, 8'h33, 1'b1);
        issue(1'b1, 16'hFFFF, 8'h44, 1'b1);
        issue(1'b0, 16'h7FFF, 8'h00, 1'b0);
        issue(1'b0, 16'h8000, 8'h00, 1'b0);
        issue(1'b0, 16'h0000, 8'h00, 1'b1);
        issue(1'b0, 16'hFFFF, 8'h00, 1'b0);
        // R8: a write between reads leaves rd_data alone
        issue(1'b1, 16'h4444, 8'h99, 1'b0);
        // R9: idle gap then mixed traffic
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < 400; i++)
            issue(1'($urandom), 16'($urandom), 8'($urandom), 1'($urandom));
        repeat (4) @(posedge clk);
        #1;
        finish_run();
    end

endmodule